// File: doc/BRIEF.md
# Two-Stage Serial Clock Generator

This block derives the serial bit clock of a half-duplex serial controller from the functional clock. It divides in two stages. The first stage is a prescaler with one global ratio, picked by a two-bit index from a table of four values: 2, 4, 7 and 10. The ratios 7 and 10 are not powers of two. The second stage divides further by 2, 4 or 8, according to the divide code of the chip select that is active. The product of the two ratios sets the serial clock period. The slowest setting divides the functional clock by 80.

The block has a small write-only register interface that holds an enable bit, the prescaler index and a polarity bit. When the polarity bit is set, the serial clock idles high. The shift engine asks for clock cycles by holding `run` high. It receives the clock together with one-cycle strobes that mark the leading edge (the clock leaving its idle level) and the trailing edge (the clock returning to it). The prescaler index and the divide code are latched while no cycle is active, so a change made during a transfer applies only from the next start.

Top module: `sclk_gen`

## Requirements
- R1: After reset, `sclk` is 0, both strobes are 0, the generator is disabled and the polarity bit is clear.
- R2: Writing address 0 stores bit 0 as the enable. While the enable is 0, `run` has no effect: `sclk` stays at its idle level and no strobe is produced.
- R3: Bits 2:1 of address 0 select the prescaler ratio: index 0 gives 2, index 1 gives 4, index 2 gives 7 and index 3 gives 10. The serial period is this ratio times the second-stage ratio, counted in input cycles.
- R4: The `div_code` input sets the second-stage ratio: code 0 gives 2, code 1 gives 4, code 2 gives 8, and code 3 also gives 8.
- R5: Let P be the prescaler ratio and D the second-stage ratio. After the first active clock edge, the first leading strobe appears P*D/2 cycles later. Each following phase of the clock lasts P*D/2 cycles.
- R6: Bit 0 of address 1 inverts `sclk`. When set, the clock idles high and its active phase is low. The strobe timing does not change.
- R7: `lead_stb` is high for exactly one cycle per period, in the first cycle of the active phase. `trail_stb` is high for one cycle, in the first cycle the clock is back at idle. The two strobes are never high together.
- R8: Clearing the enable or dropping `run` clears both divider counters. `sclk` is back at its idle level by the next cycle, and no strobe is produced. The next start again follows the R5 timing.
- R9: The prescaler index and the divide code are captured only while no cycle is active. A write of the index in the same cycle as the first active edge still runs with the previous ratio. The new ratio applies at the next start.
- R10: With index 3 and divide code 2, the serial period is 80 input cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 1 | Register select: 0 = enable and prescaler index, 1 = polarity |
| cfg_wdata | input | 3 | Write data |
| run | input | 1 | Request for serial clock cycles from the shift engine |
| div_code | input | 2 | Second-stage divide code of the active chip select |
| sclk | output | 1 | Serial clock |
| lead_stb | output | 1 | One-cycle strobe on the leading clock edge |
| trail_stb | output | 1 | One-cycle strobe on the trailing clock edge |

## Verification
A configuration write can land in the same cycle that a new clock cycle starts. The risk is that the capture of the ratio races the start of counting. The bench provokes this by raising `run` in the same cycle that it writes a new prescaler index and drives a new divide code. It then judges the outcome from the positions of the strobes, which must match the old ratios, and checks that the following start runs at the new ratios. A disable write that arrives while the clock is in its active phase is also checked: the clock must return to idle with no trailing strobe.

// File: rtl/sclk_gen_pkg.sv
`timescale 1ns/1ps
package sclk_gen_pkg;
   typedef enum logic {
      ADDR_CLKCFG = 1'b0,
      ADDR_POLCFG = 1'b1
   } cfg_addr_e;

   // number of prescaler ticks in one half period for a divide code
   function automatic int half_ticks(input int code, input int max_log);
      int sh;
      sh = (code > max_log) ? max_log : code;
      return (1 << sh);
   endfunction
endpackage

// File: rtl/sclk_cfg_regs.sv
`timescale 1ns/1ps
module sclk_cfg_regs #(
   parameter int PIDX_W  = 2,
   parameter int DCODE_W = 2,
   parameter int WDATA_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic               cfg_addr,
   input  logic [WDATA_W-1:0] cfg_wdata,
   input  logic               run,
   input  logic [DCODE_W-1:0] div_code,
   output logic               en_q,
   output logic               inv_q,
   output logic               active,
   output logic [PIDX_W-1:0]  pidx_act,
   output logic [DCODE_W-1:0] dcode_act
);
   import sclk_gen_pkg::*;

   logic [PIDX_W-1:0] pidx_q;

   assign active = en_q & run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         pidx_q <= '0;
         inv_q  <= 1'b0;
      end else if (cfg_wr) begin
         if (cfg_addr == ADDR_CLKCFG) begin
            en_q   <= cfg_wdata[0];
            pidx_q <= cfg_wdata[PIDX_W:1];
         end else begin
            inv_q  <= cfg_wdata[0];
         end
      end
   end

   // ratios are frozen for the whole of an active stretch
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pidx_act  <= '0;
         dcode_act <= '0;
      end else if (!active) begin
         pidx_act  <= pidx_q;
         dcode_act <= div_code;
      end
   end
endmodule

// File: rtl/sclk_prescale.sv
`timescale 1ns/1ps
module sclk_prescale #(
   parameter int RATIO0 = 2,
   parameter int RATIO1 = 4,
   parameter int RATIO2 = 7,
   parameter int RATIO3 = 10,
   parameter int PIDX_W = 2,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic [PIDX_W-1:0] pidx,
   output logic              tick
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] last;

   always_comb begin
      case (pidx)
         2'd0:    last = CNT_W'(RATIO0 - 1);
         2'd1:    last = CNT_W'(RATIO1 - 1);
         2'd2:    last = CNT_W'(RATIO2 - 1);
         default: last = CNT_W'(RATIO3 - 1);
      endcase
   end

   assign tick = active && (cnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cnt <= '0;
      else if (!active)  cnt <= '0;
      else if (tick)     cnt <= '0;
      else               cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/sclk_halfdiv.sv
`timescale 1ns/1ps
module sclk_halfdiv #(
   parameter int DCODE_W      = 2,
   parameter int MAX_HALF_LOG = 2,
   parameter int HC_W         = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               active,
   input  logic               tick,
   input  logic [DCODE_W-1:0] dcode,
   output logic               phase,
   output logic               lead_stb,
   output logic               trail_stb
);
   import sclk_gen_pkg::*;

   logic [HC_W-1:0] hc;
   logic [HC_W-1:0] hlim;

   always_comb begin
      hlim = HC_W'(half_ticks(int'(dcode), MAX_HALF_LOG) - 1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hc        <= '0;
         phase     <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else if (!active) begin
         hc        <= '0;
         phase     <= 1'b0;
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
      end else begin
         lead_stb  <= 1'b0;
         trail_stb <= 1'b0;
         if (tick) begin
            if (hc == hlim) begin
               hc        <= '0;
               phase     <= ~phase;
               lead_stb  <= ~phase;
               trail_stb <= phase;
            end else begin
               hc <= hc + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/sclk_gen.sv
`timescale 1ns/1ps
module sclk_gen #(
   parameter int RATIO0       = 2,
   parameter int RATIO1       = 4,
   parameter int RATIO2       = 7,
   parameter int RATIO3       = 10,
   parameter int DCODE_W      = 2,
   parameter int MAX_HALF_LOG = 2,
   parameter bit HAS_INVERT   = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_wr,
   input  logic               cfg_addr,
   input  logic [2:0]         cfg_wdata,
   input  logic               run,
   input  logic [DCODE_W-1:0] div_code,
   output logic               sclk,
   output logic               lead_stb,
   output logic               trail_stb
);
   localparam int PIDX_W    = 2;
   localparam int WDATA_W   = PIDX_W + 1;
   localparam int MAX_RATIO = (RATIO3 > RATIO2) ? RATIO3 : RATIO2;
   localparam int CNT_W     = (MAX_RATIO > 2) ? $clog2(MAX_RATIO) : 1;
   localparam int HC_W      = (MAX_HALF_LOG > 0) ? MAX_HALF_LOG : 1;

   if (RATIO0 < 2 || RATIO1 < 2 || RATIO2 < 2 || RATIO3 < 2) begin : g_bad_ratio
      $error("sclk_gen: every prescaler ratio must be at least 2");
   end
   if (MAX_HALF_LOG < 0 || MAX_HALF_LOG > 8) begin : g_bad_half
      $error("sclk_gen: MAX_HALF_LOG out of range");
   end
   if (RATIO0 > MAX_RATIO || RATIO1 > MAX_RATIO) begin : g_bad_order
      $error("sclk_gen: the largest ratio must sit at index 2 or 3");
   end

   logic              en_q;
   logic              inv_q;
   logic              active;
   logic [PIDX_W-1:0] pidx_act;
   logic [DCODE_W-1:0] dcode_act;
   logic              tick;
   logic              phase;

   sclk_cfg_regs #(.PIDX_W(PIDX_W), .DCODE_W(DCODE_W), .WDATA_W(WDATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .run(run), .div_code(div_code),
      .en_q(en_q), .inv_q(inv_q), .active(active),
      .pidx_act(pidx_act), .dcode_act(dcode_act)
   );

   sclk_prescale #(.RATIO0(RATIO0), .RATIO1(RATIO1), .RATIO2(RATIO2),
                   .RATIO3(RATIO3), .PIDX_W(PIDX_W), .CNT_W(CNT_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .active(active), .pidx(pidx_act), .tick(tick)
   );

   sclk_halfdiv #(.DCODE_W(DCODE_W), .MAX_HALF_LOG(MAX_HALF_LOG), .HC_W(HC_W)) u_half (
      .clk(clk), .rst_n(rst_n), .active(active), .tick(tick), .dcode(dcode_act),
      .phase(phase), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );

   if (HAS_INVERT) begin : g_inv
      assign sclk = phase ^ inv_q;
   end else begin : g_noinv
      assign sclk = phase;
   end
endmodule

// File: rtl/sclk_gen_chk.sv
`timescale 1ns/1ps
module sclk_gen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       run,
   input logic       cfg_wr,
   input logic       sclk,
   input logic       lead_stb,
   input logic       trail_stb,
   input logic       en_q,
   input logic       inv_q,
   input logic       phase,
   input logic       active,
   input logic [1:0] pidx_act
);
   p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(lead_stb && trail_stb));

   p_lead_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
      lead_stb |-> (sclk != inv_q));

   p_trail_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      trail_stb |-> (phase == 1'b0) && $past(phase));

   p_stop_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_q || !run) |=> (!phase && !lead_stb && !trail_stb));

   p_idle_level_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cfg_wr) |=> (sclk == inv_q));

   p_ratio_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (active && $past(active)) |-> $stable(pidx_act));
endmodule

bind sclk_gen sclk_gen_chk u_chk (
   .clk(clk), .rst_n(rst_n), .run(run), .cfg_wr(cfg_wr), .sclk(sclk),
   .lead_stb(lead_stb), .trail_stb(trail_stb), .en_q(en_q), .inv_q(inv_q),
   .phase(phase), .active(active), .pidx_act(pidx_act)
);

// File: tb/sclk_gen_bench.sv
`timescale 1ns/1ps
module sclk_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_wr = 1'b0;
   logic       cfg_addr = 1'b0;
   logic [2:0] cfg_wdata = '0;
   logic       run = 1'b0;
   logic [1:0] div_code = '0;
   logic       sclk, lead_stb, trail_stb;

   int checks = 0;
   int fails  = 0;
   int rat[4] = '{2, 4, 7, 10};
   int dv[4]  = '{2, 4, 8, 8};

   always #2 clk = ~clk;

   sclk_gen u_sclk_gen (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .run(run), .div_code(div_code),
      .sclk(sclk), .lead_stb(lead_stb), .trail_stb(trail_stb)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(input bit addr, input logic [2:0] data);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = addr; cfg_wdata = data;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   // called when the first active edge is the next posedge
   task automatic observe(input int p, input int d, input bit inv, input bit drop_wr,
                          input string req);
      int hp = p * d / 2;
      int l1 = 0, tr = 0, l2 = 0, lvl = -1, both = 0;
      for (int n = 1; n <= 3 * hp + 4; n++) begin
         @(negedge clk);
         if (drop_wr) cfg_wr = 1'b0;
         if (lead_stb && trail_stb) both++;
         if (lead_stb) begin
            if (l1 == 0) begin l1 = n; lvl = int'(sclk); end
            else if (l2 == 0) l2 = n;
         end
         if (trail_stb && tr == 0) tr = n;
      end
      check(l1 == hp, {req, " R5 first lead"}, l1, hp);
      check(tr == 2 * hp, {req, " R5 trail"}, tr, 2 * hp);
      check(l2 == 3 * hp, {req, " period"}, l2 - l1, 2 * hp);
      check(lvl == int'(!inv), {req, " R7 level at lead"}, lvl, int'(!inv));
      check(both == 0, {req, " R7 strobes exclusive"}, both, 0);
   endtask

   task automatic stop_run(input bit inv);
      @(negedge clk); run = 1'b0;
      @(negedge clk);
      check(sclk == inv && !lead_stb && !trail_stb, "R8 idle after run drop",
            int'(sclk), int'(inv));
   endtask

   task automatic t_reset;
      check(sclk == 1'b0, "R1 sclk", int'(sclk), 0);
      check(!lead_stb && !trail_stb, "R1 strobes", int'(lead_stb) + int'(trail_stb), 0);
   endtask

   task automatic t_disabled;
      int s = 0, hi = 0;
      @(negedge clk); run = 1'b1;
      for (int n = 0; n < 60; n++) begin
         @(negedge clk);
         s += int'(lead_stb) + int'(trail_stb);
         hi += int'(sclk);
      end
      check(s == 0, "R2 no strobes while disabled", s, 0);
      check(hi == 0, "R2 sclk idle while disabled", hi, 0);
      run = 1'b0;
   endtask

   task automatic t_ratios;
      for (int i = 0; i < 4; i++) begin
         wr(1'b0, {2'(i), 1'b1});
         div_code = 2'd0;
         @(negedge clk); run = 1'b1;
         observe(rat[i], 2, 1'b0, 1'b0, "R3 prescaler");
         stop_run(1'b0);
      end
   endtask

   task automatic t_divs;
      wr(1'b0, 3'b001);
      for (int c = 0; c < 4; c++) begin
         div_code = 2'(c);
         @(negedge clk); run = 1'b1;
         observe(2, dv[c], 1'b0, 1'b0, "R4 second stage");
         stop_run(1'b0);
      end
   endtask

   task automatic t_slowest;
      wr(1'b0, 3'b111);
      div_code = 2'd2;
      @(negedge clk); run = 1'b1;
      observe(10, 8, 1'b0, 1'b0, "R10 slowest");
      stop_run(1'b0);
   endtask

   task automatic t_invert;
      wr(1'b0, 3'b001);
      div_code = 2'd1;
      wr(1'b1, 3'b001);
      @(negedge clk);
      check(sclk == 1'b1, "R6 idle high", int'(sclk), 1);
      run = 1'b1;
      observe(2, 4, 1'b1, 1'b0, "R6 inverted");
      stop_run(1'b1);
      wr(1'b1, 3'b000);
      @(negedge clk);
      check(sclk == 1'b0, "R6 idle low again", int'(sclk), 0);
   endtask

   task automatic t_stop;
      int bad = 0;
      wr(1'b0, 3'b001);
      div_code = 2'd2;
      @(negedge clk); run = 1'b1;
      repeat (10) @(negedge clk);
      check(sclk == 1'b1, "R8 in active phase before disable", int'(sclk), 1);
      wr(1'b0, 3'b000);
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         bad += int'(sclk) + int'(lead_stb) + int'(trail_stb);
      end
      check(bad == 0, "R8 disable mid-phase idles silently", bad, 0);
      wr(1'b0, 3'b001);
      observe(2, 8, 1'b0, 1'b0, "R8 restart after enable");
      @(negedge clk); run = 1'b0;
      repeat (3) @(negedge clk);
      run = 1'b1;
      repeat (10) @(negedge clk);
      run = 1'b0;
      @(negedge clk);
      check(sclk == 1'b0 && !trail_stb, "R8 run drop mid-phase", int'(sclk), 0);
      run = 1'b1;
      observe(2, 8, 1'b0, 1'b0, "R8 restart after run");
      stop_run(1'b0);
   endtask

   task automatic t_collide;
      wr(1'b0, 3'b001);
      div_code = 2'd0;
      @(negedge clk);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_addr = 1'b0; cfg_wdata = 3'b111;
      run = 1'b1; div_code = 2'd2;
      observe(2, 2, 1'b0, 1'b1, "R9 same-cycle write keeps old ratios");
      stop_run(1'b0);
      @(negedge clk); run = 1'b1;
      observe(10, 8, 1'b0, 1'b0, "R9 new ratios at next start");
      stop_run(1'b0);
   endtask

   initial begin
      #(4 * 150000);
      checks++; fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_disabled();
      t_ratios();
      t_divs();
      t_slowest();
      t_invert();
      t_stop();
      t_collide();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule